// File: doc/BRIEF.md
# Debug Command Transaction Sequencer

This block sits behind a single-wire debug link's frame receiver and follows the transaction layer of the link. Every frame the receiver has acknowledged arrives as a one-cycle strobe with its payload and the direction bit taken from the frame's start bit. The sequencer tells the receiver which frame length to expect next. In command mode a frame has a 3-bit payload. In every other state it has an 8-bit payload.

A transaction opens with a command: system reset, read on-the-fly, write on-the-fly, or an unrecognised code. Reset and unrecognised codes are reported and the sequencer stays in command mode. Read and write go on to collect a length byte and then a 24-bit address, sent as three bytes with the most significant byte first. After that, each data byte is reported with its value and direction and lowers the remaining count. When the count runs out, the sequencer returns to command mode. A synchronisation pulse from the receiver returns it to command mode from any state. Memory access is left to the consumer of the data strobe.

Top module: `dbg_txn_seq`

## Requirements
- R1: After reset, `cmd_mode` is 1, `addr_o` and `count_o` are 0, and neither `cmd_valid` nor `data_valid` is high.
- R2: In command mode an accepted frame decodes `frm_payload[2:0]` as follows: 3'b000 is system reset (kind 0), 3'b001 is read (kind 1), 3'b010 is write (kind 2), and any other value is unknown (kind 3). `frm_payload[7:3]` is ignored. The next cycle shows `cmd_valid` high for one cycle with `cmd_kind` holding the kind.
- R3: A reset or unknown command leaves `cmd_mode` at 1. A read or write command clears `cmd_mode` in the same cycle that `cmd_valid` is shown.
- R4: The first byte after a read or write command is loaded into `count_o` and appears on the cycle after it is accepted.
- R5: A read or write command clears `addr_o`. Each of the next three bytes is then shifted into `addr_o` from the low end, so the first byte ends up in bits 23:16 and the third byte in bits 7:0.
- R6: After the address, every accepted byte pulses `data_valid` for one cycle with `data_byte` set to the payload and `data_dir` set to `frm_dir`. In that same cycle `count_o` drops by one, and it stays at zero if it was already zero.
- R7: The sequencer returns to command mode on the data byte after which the count is zero. A length of 0 therefore transfers exactly one data byte.
- R8: `sync_req` forces command mode and clears `addr_o` and `count_o` on the next cycle. It takes priority over a frame in the same cycle, and that frame produces no strobe.
- R9: In a cycle with neither `frm_valid` nor `sync_req`, `addr_o`, `count_o` and the mode do not change, and no strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | An acknowledged frame is present this cycle |
| frm_payload | input | 8 | Frame payload; only bits 2:0 are used in command mode |
| frm_dir | input | 1 | Direction from the frame's start bit (1 = from target) |
| sync_req | input | 1 | Synchronisation frame seen; returns to command mode |
| cmd_mode | output | 1 | Next frame is a 3-bit command |
| cmd_valid | output | 1 | One-cycle strobe: a command was decoded |
| cmd_kind | output | 2 | Decoded command kind (0 reset, 1 read, 2 write, 3 unknown) |
| addr_o | output | 24 | Transaction address |
| count_o | output | 8 | Remaining byte count |
| data_valid | output | 1 | One-cycle strobe: a data byte was accepted |
| data_byte | output | 8 | Value of the data byte |
| data_dir | output | 1 | Direction of the data byte |

## Verification
On every cycle the assertions check four things. Reset and unknown commands keep command mode while read and write leave it. Each data strobe brings a saturating one-step count decrement, and a strobe that empties the count lands in command mode. A sync pulse yields a cleared, command-mode state, and idle cycles leave the state untouched. Only the bench's scenarios can show the rest, because it depends on whole frame sequences: the big-endian assembly of the address, the loaded length, the value and direction of each data byte, the one-byte transfer for a length of zero, and the loss of a frame that arrives together with a sync pulse.

// File: rtl/dts_pkg.sv
package dts_pkg;
  typedef enum logic [1:0] {ST_CMD, ST_CNT, ST_ADDR, ST_DATA} seq_state_t;
  typedef enum logic [1:0] {CK_SRST = 2'd0, CK_READ = 2'd1, CK_WRITE = 2'd2, CK_UNKNOWN = 2'd3} cmd_kind_t;

  // Map a 3-bit command code to its kind.
  function automatic cmd_kind_t decode_cmd(input logic [2:0] code);
    case (code)
      3'd0:    return CK_SRST;
      3'd1:    return CK_READ;
      3'd2:    return CK_WRITE;
      default: return CK_UNKNOWN;
    endcase
  endfunction

  function automatic logic opens_transfer(input cmd_kind_t k);
    return (k == CK_READ) || (k == CK_WRITE);
  endfunction
endpackage

// File: rtl/dts_ctrl.sv
module dts_ctrl
  import dts_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_valid,
  input  logic             sync_req,
  input  cmd_kind_t        kind,
  input  logic [CNT_W-1:0] cnt_q,
  output logic             in_cmd,
  output logic             ev_cmd,
  output logic             ev_open,
  output logic             ev_len,
  output logic             ev_addr,
  output logic             ev_data,
  output logic             ev_last
);
  localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ADDR_BYTES - 1);

  seq_state_t       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    ev_cmd  = 1'b0;
    ev_open = 1'b0;
    ev_len  = 1'b0;
    ev_addr = 1'b0;
    ev_data = 1'b0;
    ev_last = 1'b0;
    if (sync_req) begin
      st_d  = ST_CMD;
      idx_d = '0;
    end else if (frm_valid) begin
      case (st_q)
        ST_CMD: begin
          ev_cmd = 1'b1;
          if (opens_transfer(kind)) begin
            ev_open = 1'b1;
            st_d    = ST_CNT;
          end
        end
        ST_CNT: begin
          ev_len = 1'b1;
          idx_d  = '0;
          st_d   = ST_ADDR;
        end
        ST_ADDR: begin
          ev_addr = 1'b1;
          if (idx_q == IDX_LAST) st_d = ST_DATA;
          else idx_d = idx_q + 1'b1;
        end
        default: begin
          ev_data = 1'b1;
          if (cnt_q <= CNT_W'(1)) begin
            ev_last = 1'b1;
            st_d    = ST_CMD;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_CMD;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign in_cmd = (st_q == ST_CMD);
endmodule

// File: rtl/dts_regs.sv
module dts_regs #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_req,
  input  logic              ev_open,
  input  logic              ev_len,
  input  logic              ev_addr,
  input  logic              ev_data,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q
);
  function automatic logic [CNT_W-1:0] dec_sat(input logic [CNT_W-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] shift_in(input logic [ADDR_W-1:0] a,
                                                  input logic [BYTE_W-1:0] b);
    return {a[ADDR_W-BYTE_W-1:0], b};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || sync_req) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (ev_open)      addr_q <= '0;
      else if (ev_addr) addr_q <= shift_in(addr_q, byte_in);
      if (ev_len)       cnt_q  <= CNT_W'(byte_in);
      else if (ev_data) cnt_q  <= dec_sat(cnt_q);
    end
  end
endmodule

// File: rtl/dts_report.sv
module dts_report #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_cmd,
  input  logic [1:0]        kind,
  input  logic              ev_data,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              dir_in,
  output logic              cmd_valid,
  output logic [1:0]        cmd_kind,
  output logic              data_valid,
  output logic [BYTE_W-1:0] data_byte,
  output logic              data_dir
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid  <= 1'b0;
      cmd_kind   <= '0;
      data_valid <= 1'b0;
      data_byte  <= '0;
      data_dir   <= 1'b0;
    end else begin
      cmd_valid  <= ev_cmd;
      data_valid <= ev_data;
      if (ev_cmd) cmd_kind <= kind;
      if (ev_data) begin
        data_byte <= byte_in;
        data_dir  <= dir_in;
      end
    end
  end
endmodule

// File: rtl/dbg_txn_seq.sv
module dbg_txn_seq
  import dts_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int ADDR_BYTES = 3,
  parameter int CNT_W      = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frm_valid,
  input  logic [BYTE_W-1:0]          frm_payload,
  input  logic                       frm_dir,
  input  logic                       sync_req,
  output logic                       cmd_mode,
  output logic                       cmd_valid,
  output logic [1:0]                 cmd_kind,
  output logic [BYTE_W*ADDR_BYTES-1:0] addr_o,
  output logic [CNT_W-1:0]           count_o,
  output logic                       data_valid,
  output logic [BYTE_W-1:0]          data_byte,
  output logic                       data_dir
);
  localparam int ADDR_W = BYTE_W * ADDR_BYTES;

  // Named internal events, visible to the bound checker.
  cmd_kind_t kind;
  logic ev_cmd, ev_open, ev_len, ev_addr, ev_data, ev_last;

  assign kind = decode_cmd(frm_payload[2:0]);

  dts_ctrl #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .sync_req(sync_req),
    .kind(kind), .cnt_q(count_o), .in_cmd(cmd_mode),
    .ev_cmd(ev_cmd), .ev_open(ev_open), .ev_len(ev_len), .ev_addr(ev_addr),
    .ev_data(ev_data), .ev_last(ev_last)
  );

  dts_regs #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .ev_open(ev_open),
    .ev_len(ev_len), .ev_addr(ev_addr), .ev_data(ev_data),
    .byte_in(frm_payload), .addr_q(addr_o), .cnt_q(count_o)
  );

  dts_report #(.BYTE_W(BYTE_W)) u_rep (
    .clk(clk), .rst_n(rst_n), .ev_cmd(ev_cmd), .kind(kind),
    .ev_data(ev_data), .byte_in(frm_payload), .dir_in(frm_dir),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .data_valid(data_valid),
    .data_byte(data_byte), .data_dir(data_dir)
  );
endmodule

// File: rtl/dts_checker.sv
module dts_checker #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_valid,
  input logic              sync_req,
  input logic              cmd_mode,
  input logic              cmd_valid,
  input logic [1:0]        cmd_kind,
  input logic [ADDR_W-1:0] addr_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              data_valid,
  input logic              ev_data,
  input logic              ev_last
);
  assert_stay_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_kind == 2'd0 || cmd_kind == 2'd3)) |-> cmd_mode);

  assert_leave_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_kind == 2'd1 || cmd_kind == 2'd2)) |-> !cmd_mode);

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, data_valid}));

  assert_data_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data |=> data_valid);

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data |=> (count_o == (($past(count_o) == '0) ? '0 : $past(count_o) - 1'b1)));

  assert_done_to_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last |=> (cmd_mode && count_o == '0));

  assert_sync_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |=> (cmd_mode && addr_o == '0 && count_o == '0 && !data_valid && !cmd_valid));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!frm_valid && !sync_req) |=> ($stable(addr_o) && $stable(count_o) && $stable(cmd_mode)
                                   && !cmd_valid && !data_valid));
endmodule

bind dbg_txn_seq dts_checker #(.ADDR_W(BYTE_W*ADDR_BYTES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .sync_req(sync_req),
  .cmd_mode(cmd_mode), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
  .addr_o(addr_o), .count_o(count_o), .data_valid(data_valid),
  .ev_data(ev_data), .ev_last(ev_last)
);

// File: tb/sim_dbg_txn_seq.sv
module sim_dbg_txn_seq;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0;
  logic [7:0]  frm_payload = '0;
  logic        frm_dir = 1'b0;
  logic        sync_req = 1'b0;
  logic        cmd_mode, cmd_valid, data_valid, data_dir;
  logic [1:0]  cmd_kind;
  logic [23:0] addr_o;
  logic [7:0]  count_o, data_byte;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Scoreboard item: [9] 1 = data item, [8] dir, [7:0] value (or kind for commands).
  logic [9:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_txn_seq u0 (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_payload(frm_payload),
    .frm_dir(frm_dir), .sync_req(sync_req), .cmd_mode(cmd_mode),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .addr_o(addr_o),
    .count_o(count_o), .data_valid(data_valid), .data_byte(data_byte),
    .data_dir(data_dir)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic expect_cmd(input logic [1:0] k, input string tag);
    exp_q.push_back({1'b0, 1'b0, 6'd0, k});
    tag_q.push_back(tag);
  endtask

  task automatic expect_data(input logic [7:0] v, input logic d, input string tag);
    exp_q.push_back({1'b1, d, v});
    tag_q.push_back(tag);
  endtask

  // Monitor: compare each strobe with the head of the expectation queue.
  always @(negedge clk) begin
    if (rst_n && (cmd_valid || data_valid)) begin
      logic [9:0] got;
      got = cmd_valid ? {2'b00, 6'd0, cmd_kind} : {1'b1, data_dir, data_byte};
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected strobe", {22'd0, got}, 32'd0);
      end else begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(got == e, t, {22'd0, got}, {22'd0, e});
      end
    end
  end

  task automatic send(input logic [7:0] v, input logic d, input logic s);
    @(negedge clk);
    frm_valid   = 1'b1;
    frm_payload = v;
    frm_dir     = d;
    sync_req    = s;
    @(negedge clk);
    frm_valid = 1'b0;
    sync_req  = 1'b0;
  endtask

  task automatic pulse_sync();
    @(negedge clk);
    sync_req = 1'b1;
    @(negedge clk);
    sync_req = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [23:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cmd_mode == 1'b1, "R1 cmd_mode", {31'd0, cmd_mode}, 32'd1);
    chk(addr_o == 24'd0 && count_o == 8'd0, "R1 addr/count", {addr_o, count_o}, 32'd0);
    chk(!cmd_valid && !data_valid, "R1 strobes", {30'd0, cmd_valid, data_valid}, 32'd0);

    // R2/R3: system reset with upper bits set, stays in command mode
    expect_cmd(2'd0, "R2 reset code");
    send(8'hF8, 1'b0, 1'b0);
    chk(cmd_mode, "R3 stay after reset cmd", {31'd0, cmd_mode}, 32'd1);

    // R2/R3: unknown code
    expect_cmd(2'd3, "R2 unknown code");
    send(8'h05, 1'b0, 1'b0);
    chk(cmd_mode, "R3 stay after unknown", {31'd0, cmd_mode}, 32'd1);

    // Write transfer of 3 bytes
    expect_cmd(2'd2, "R2 write code");
    send(8'h02, 1'b0, 1'b0);
    chk(!cmd_mode, "R3 leave on write", {31'd0, cmd_mode}, 32'd0);
    send(8'h03, 1'b0, 1'b0);
    chk(count_o == 8'd3, "R4 length load", {24'd0, count_o}, 32'd3);
    send(8'h12, 1'b0, 1'b0);
    send(8'h34, 1'b0, 1'b0);
    send(8'h56, 1'b0, 1'b0);
    chk(addr_o == 24'h123456, "R5 address order", {8'd0, addr_o}, 32'h123456);
    expect_data(8'hA0, 1'b0, "R6 write byte 0");
    send(8'hA0, 1'b0, 1'b0);
    chk(count_o == 8'd2, "R6 decrement", {24'd0, count_o}, 32'd2);
    expect_data(8'hA1, 1'b0, "R6 write byte 1");
    send(8'hA1, 1'b0, 1'b0);
    expect_data(8'hA2, 1'b0, "R6 write byte 2");
    send(8'hA2, 1'b0, 1'b0);
    chk(cmd_mode && count_o == 8'd0, "R7 back to command", {23'd0, cmd_mode, count_o}, 32'h100);

    // Read transfer of 2 bytes with idle gaps
    expect_cmd(2'd1, "R2 read code");
    send(8'h01, 1'b1, 1'b0);
    chk(!cmd_mode, "R3 leave on read", {31'd0, cmd_mode}, 32'd0);
    chk(addr_o == 24'd0, "R5 address cleared", {8'd0, addr_o}, 32'd0);
    send(8'h02, 1'b0, 1'b0);
    send(8'hAB, 1'b0, 1'b0);
    send(8'hCD, 1'b0, 1'b0);
    held = addr_o;
    repeat (4) @(negedge clk);
    chk(addr_o == held && count_o == 8'd2 && !cmd_mode, "R9 idle hold",
        {addr_o, count_o}, {held, 8'd2});
    send(8'hEF, 1'b0, 1'b0);
    chk(addr_o == 24'hABCDEF, "R5 read address", {8'd0, addr_o}, 32'hABCDEF);
    expect_data(8'h5A, 1'b1, "R6 read byte dir");
    send(8'h5A, 1'b1, 1'b0);
    expect_data(8'hC3, 1'b1, "R6 read byte dir 2");
    send(8'hC3, 1'b1, 1'b0);
    chk(cmd_mode, "R7 read done", {31'd0, cmd_mode}, 32'd1);

    // Length zero: a single data byte then command mode
    expect_cmd(2'd2, "R2 write code z");
    send(8'h02, 1'b0, 1'b0);
    send(8'h00, 1'b0, 1'b0);
    send(8'h00, 1'b0, 1'b0);
    send(8'h00, 1'b0, 1'b0);
    send(8'h07, 1'b0, 1'b0);
    expect_data(8'h99, 1'b0, "R7 zero length byte");
    send(8'h99, 1'b0, 1'b0);
    chk(cmd_mode && count_o == 8'd0, "R7 zero length ends", {23'd0, cmd_mode, count_o}, 32'h100);

    // Sync mid-address
    expect_cmd(2'd1, "R2 read before sync");
    send(8'h01, 1'b1, 1'b0);
    send(8'h05, 1'b0, 1'b0);
    send(8'h11, 1'b0, 1'b0);
    send(8'h22, 1'b0, 1'b0);
    pulse_sync();
    chk(cmd_mode && addr_o == 24'd0 && count_o == 8'd0, "R8 sync clears",
        {7'd0, cmd_mode, addr_o}, 32'h1000000);

    // Sync together with a data frame: the frame is dropped
    expect_cmd(2'd2, "R2 write before sync");
    send(8'h02, 1'b0, 1'b0);
    send(8'h04, 1'b0, 1'b0);
    send(8'h01, 1'b0, 1'b0);
    send(8'h02, 1'b0, 1'b0);
    send(8'h03, 1'b0, 1'b0);
    send(8'h77, 1'b0, 1'b1);
    chk(cmd_mode && count_o == 8'd0, "R8 sync wins over frame", {23'd0, cmd_mode, count_o}, 32'h100);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule